// File: doc/BRIEF.md
# VSYNC-Clocked EDID Serial Transmitter

This block sends a 128-byte version 1 EDID structure from a local byte memory onto the display data line. It uses the video vertical sync as its bit clock. Each rising edge of VSYNC puts out one bit, so the host can read the display's identity without any serial clock of its own. The link runs in one direction only: the display transmits and the host listens. The data line is open drain. The block only ever pulls it low or lets it float high.

Bytes come from memory through a small fetch engine. Each fetch takes the memory bus for exactly two system clock cycles and stalls the processor while it does. A 3-bit mode code chooses whether this VSYNC-clocked channel may run at all. The code can only be loaded while the block is disabled. The transmitter streams the structure again and again from byte 0, wrapping after the last byte, until it is disabled.

Top module: `ddc1_edid_tx`

## Requirements
- R1: VSYNC is passed through a two-flop synchronizer. Only its synchronized rising edges move the line to the next bit. A falling edge leaves `sda_drive_low` unchanged.
- R2: Each byte is sent as 9 bit slots. The first 8 slots carry the data, most significant bit first. The ninth slot is always released. `sda_drive_low`=1 means a 0 bit, and 0 means the line is released (a 1 bit).
- R3: The transmitter runs only when `cfg_en` is high and the stored mode code is 3'b000 or 3'b010. `ddc1_active` reports this condition two clock edges after `cfg_en` rises.
- R4: A mode write (`cfg_wr` with `cfg_mode`) takes effect only while the block is disabled. A write while enabled is ignored, and the stored code is kept through later enables.
- R5: Each byte fetch raises `mem_rd` for one cycle and `cpu_stall` for exactly two consecutive cycles. The fetch of the next byte starts during the ninth slot of the current byte.
- R6: Bytes are read at addresses 0, 1, 2 and so on. After address 127 the address wraps to 0, so the structure repeats.
- R7: When disabled, the block releases SDA and resets its byte address to 0. The next enable starts again from byte 0.
- R8: For any mode code other than 3'b000 or 3'b010, no fetch is made and SDA stays released, even while VSYNC pulses.
- R9: On activation, byte 0 is fetched at once. Its most significant bit appears at the first VSYNC rising edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transmitter enable (level) |
| cfg_wr | input | 1 | Strobe that loads `cfg_mode` |
| cfg_mode | input | 3 | Mode code to store |
| vsync_in | input | 1 | Asynchronous video vertical sync, used as the bit clock |
| mem_addr | output | 7 | Byte address for the memory read |
| mem_rd | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| cpu_stall | output | 1 | Processor stall while the fetch holds the bus |
| sda_drive_low | output | 1 | Open-drain data line: 1 pulls low |
| ddc1_active | output | 1 | The VSYNC-clocked channel is running |

## Verification
A wrong bit counter or shift register shows up at the very next VSYNC edge, as a wrong level or a ninth slot that is not released. The bench therefore compares every slot of the stream against the memory pattern. A stale byte address is not visible until the next fetch. It then shows up on `mem_addr`, and one VSYNC later as a byte that does not match, so the wrap and re-enable cases are checked at the fetch and on the line. A broken mode latch shows up in `ddc1_active` two cycles after enable, and a broken fetch engine shows up on `cpu_stall` within that same fetch.

// File: rtl/ddc1_tx_pkg.sv
package ddc1_tx_pkg;

  typedef enum logic [1:0] {
    FETCH_IDLE = 2'd0,
    FETCH_ADDR = 2'd1,
    FETCH_CAPT = 2'd2
  } fetch_state_t;

  // only two codes let the vsync-clocked channel run
  function automatic logic mode_allows_tx(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b010);
  endfunction

endpackage

// File: rtl/ddc1_vsync_edge.sv
module ddc1_vsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R1
endmodule

// File: rtl/ddc1_byte_fetch.sv
module ddc1_byte_fetch
  import ddc1_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cpu_stall,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  fetch_state_t      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, stall_q, done_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FETCH_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      stall_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        FETCH_IDLE: begin
          if (!active) begin
            addr_q <= '0;
          end else if (req) begin
            state_q <= FETCH_ADDR;
            rd_q    <= 1'b1;
            stall_q <= 1'b1;
          end
        end
        FETCH_ADDR: begin
          rd_q    <= 1'b0;
          state_q <= FETCH_CAPT;
        end
        FETCH_CAPT: begin
          // a fetch in flight always completes so the stall stays two cycles
          stall_q <= 1'b0;
          state_q <= FETCH_IDLE;
          if (active) begin
            data_q <= mem_rdata;
            done_q <= 1'b1;
            addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
          end else begin
            addr_q <= '0;
          end
        end
        default: state_q <= FETCH_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = rd_q;
  assign cpu_stall = stall_q;
  assign done      = done_q;
  assign data      = data_q;

  AST_STALL_SECOND: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |=> cpu_stall); // R5
  AST_STALL_TWO_MAX: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && $past(cpu_stall)) |=> !cpu_stall); // R5
  AST_RD_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> cpu_stall); // R5
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (done && $past(mem_addr) == LAST_ADDR) |-> (mem_addr == '0)); // R6
endmodule

// File: rtl/ddc1_bit_shift.sv
module ddc1_bit_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rise,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  output logic              fetch_req,
  output logic              drive_low
);
  localparam int SLOTS = DATA_W + 1;
  localparam int IDX_W = $clog2(SLOTS + 1);
  localparam logic [IDX_W-1:0] IDX_GAP  = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q, buf_q;
  logic              buf_ok_q, prev_act_q, req_q, low_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      idx_q      <= IDX_GAP;
      shreg_q    <= '0;
      buf_q      <= '0;
      buf_ok_q   <= 1'b0;
      prev_act_q <= 1'b0;
      req_q      <= 1'b0;
      low_q      <= 1'b0;
    end else begin
      prev_act_q <= 1'b1;
      req_q      <= !prev_act_q;
      if (load_valid) begin
        buf_q    <= load_data;
        buf_ok_q <= 1'b1;
      end
      if (rise) begin
        if (idx_q == IDX_GAP) begin
          if (buf_ok_q) begin
            low_q    <= ~buf_q[DATA_W-1];
            shreg_q  <= buf_q << 1;
            idx_q    <= '0;
            buf_ok_q <= 1'b0;
          end
        end else if (idx_q == IDX_LAST) begin
          low_q <= 1'b0;
          idx_q <= IDX_GAP;
          req_q <= 1'b1;
        end else begin
          low_q   <= ~shreg_q[DATA_W-1];
          shreg_q <= shreg_q << 1;
          idx_q   <= idx_q + 1'b1;
        end
      end
    end
  end

  assign fetch_req = req_q;
  assign drive_low = low_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !active |=> !drive_low); // R7
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(rise)) |-> $stable(drive_low)); // R1
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx
  import ddc1_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_mode,
  input  logic              vsync_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cpu_stall,
  output logic              sda_drive_low,
  output logic              ddc1_active
);
  logic              en_q, active_q;
  logic [2:0]        mode_q;
  logic              vs_rise, req, done;
  logic [DATA_W-1:0] fetched;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      mode_q   <= 3'b000;
      active_q <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (cfg_wr && !en_q) mode_q <= cfg_mode;
      active_q <= en_q && mode_allows_tx(mode_q);
    end
  end

  ddc1_vsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(vsync_in), .rise(vs_rise)
  );

  ddc1_byte_fetch #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fetch (
    .clk(clk), .rst(rst), .active(active_q), .req(req),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .cpu_stall(cpu_stall), .done(done), .data(fetched)
  );

  ddc1_bit_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active_q), .rise(vs_rise),
    .load_valid(done), .load_data(fetched),
    .fetch_req(req), .drive_low(sda_drive_low)
  );

  assign ddc1_active = active_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(mode_q)); // R4
  AST_ACTIVE_CODE: assert property (@(posedge clk) disable iff (rst)
    ddc1_active |-> (mode_q == 3'b000 || mode_q == 3'b010)); // R3
  AST_NO_FETCH_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ddc1_active && !cpu_stall) |=> !mem_rd); // R8
endmodule

// File: tb/sim_ddc1_edid_tx.sv
`timescale 1ns/1ps
module sim_ddc1_edid_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0, cfg_wr = 1'b0, vsync_in = 1'b0;
  logic [2:0] cfg_mode = 3'b000;
  logic [6:0] mem_addr;
  logic       mem_rd, cpu_stall, sda_drive_low, ddc1_active;
  logic [7:0] mem_rdata = 8'h00;

  int checks = 0, errors = 0;
  logic mon_clr = 1'b0;
  int rd_cnt = 0, stall_cnt = 0, run_len = 0, bad_runs = 0;
  logic [6:0] rd_log [0:255];

  always #2.5 clk = ~clk;

  ddc1_edid_tx u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .vsync_in(vsync_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .cpu_stall(cpu_stall), .sda_drive_low(sda_drive_low), .ddc1_active(ddc1_active)
  );

  function automatic logic [7:0] pat(input int i);
    logic [7:0] a = 8'(i);
    return (a * 8'd29 + 8'd83) ^ (a >> 1);
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_addr));

  always @(posedge clk) begin
    if (mon_clr) begin
      rd_cnt <= 0; stall_cnt <= 0; run_len <= 0; bad_runs <= 0;
    end else begin
      if (mem_rd) begin
        if (rd_cnt < 256) rd_log[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
      if (cpu_stall) begin
        stall_cnt <= stall_cnt + 1;
        run_len   <= run_len + 1;
      end else if (run_len != 0) begin
        if (run_len != 2) bad_runs <= bad_runs + 1;
        run_len <= 0;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1; wait_cyc(1); mon_clr = 1'b0;
  endtask

  task automatic write_mode(input logic [2:0] code);
    cfg_mode = code; cfg_wr = 1'b1; wait_cyc(1); cfg_wr = 1'b0;
  endtask

  task automatic disable_tx();
    cfg_en = 1'b0; wait_cyc(6);
  endtask

  task automatic enable_tx();
    clear_mon();
    cfg_en = 1'b1; wait_cyc(12);
  endtask

  // one vsync pulse; the slot level is compared while vsync is high
  task automatic slot(input logic [7:0] b, input int pos, input string req);
    logic exp_low;
    exp_low = (pos < 8) ? !b[7-pos] : 1'b0;
    vsync_in = 1'b1; wait_cyc(4);
    check(sda_drive_low == exp_low, req, $sformatf("slot %0d of %02h", pos, b),
          int'(sda_drive_low), int'(exp_low));
    vsync_in = 1'b0; wait_cyc(6);
  endtask

  task automatic send_byte(input int idx, input string req);
    for (int p = 0; p < 9; p++) slot(pat(idx), p, req);
  endtask

  task automatic t_reset();
    check(sda_drive_low == 1'b0, "R7", "reset sda", int'(sda_drive_low), 0);
    check(ddc1_active == 1'b0, "R3", "reset active", int'(ddc1_active), 0);
    check(cpu_stall == 1'b0 && mem_rd == 1'b0, "R8", "reset fetch",
          int'(cpu_stall), 0);
  endtask

  task automatic t_modes();
    for (int c = 0; c < 8; c++) begin
      logic ok;
      ok = (c == 0) || (c == 2);
      write_mode(3'(c));
      enable_tx();
      check(ddc1_active == ok, "R3", $sformatf("active code %0d", c),
            int'(ddc1_active), int'(ok));
      if (!ok) begin
        for (int k = 0; k < 3; k++) begin
          vsync_in = 1'b1; wait_cyc(4);
          check(sda_drive_low == 1'b0, "R8", $sformatf("sda code %0d", c),
                int'(sda_drive_low), 0);
          vsync_in = 1'b0; wait_cyc(6);
        end
        check(rd_cnt == 0 && stall_cnt == 0, "R8",
              $sformatf("fetches code %0d", c), rd_cnt, 0);
      end else begin
        check(stall_cnt == 2, "R5", "stall on activation", stall_cnt, 2);
      end
      disable_tx();
    end
  endtask

  task automatic t_stream();
    write_mode(3'b000);
    enable_tx();
    check(rd_cnt == 1 && rd_log[0] == 7'd0, "R9", "first fetch addr 0",
          rd_cnt, 1);
    // falling edge alone must not advance the line
    vsync_in = 1'b1; wait_cyc(4);
    check(sda_drive_low == !pat(0)[7], "R9", "msb at first edge",
          int'(sda_drive_low), int'(!pat(0)[7]));
    vsync_in = 1'b0; wait_cyc(6);
    check(sda_drive_low == !pat(0)[7], "R1", "fall keeps level",
          int'(sda_drive_low), int'(!pat(0)[7]));
    for (int p = 1; p < 8; p++) slot(pat(0), p, "R2");
    check(rd_cnt == 1, "R5", "no fetch before ninth slot", rd_cnt, 1);
    slot(pat(0), 8, "R2");
    check(rd_cnt == 2 && rd_log[1] == 7'd1, "R5", "fetch in ninth slot",
          rd_cnt, 2);
    send_byte(1, "R2");
    send_byte(2, "R2");
    check(stall_cnt == 8 && bad_runs == 0, "R5", "two stall cycles each",
          stall_cnt, 8);
    check(rd_log[3] == 7'd3, "R6", "sequential address", int'(rd_log[3]), 3);
    disable_tx();
  endtask

  task automatic t_wrap();
    write_mode(3'b010);
    enable_tx();
    for (int b = 0; b < 130; b++) send_byte(b % 128, b >= 126 ? "R6" : "R2");
    check(rd_log[127] == 7'd127, "R6", "last address", int'(rd_log[127]), 127);
    check(rd_log[128] == 7'd0, "R6", "wrap to zero", int'(rd_log[128]), 0);
    check(bad_runs == 0, "R5", "stall run length", bad_runs, 0);
    disable_tx();
  endtask

  task automatic t_locked_mode();
    write_mode(3'b000);
    enable_tx();
    write_mode(3'b011);
    wait_cyc(4);
    check(ddc1_active == 1'b1, "R4", "write while enabled ignored",
          int'(ddc1_active), 1);
    send_byte(0, "R4");
    disable_tx();
    check(ddc1_active == 1'b0, "R3", "inactive after disable",
          int'(ddc1_active), 0);
    enable_tx();
    check(ddc1_active == 1'b1, "R4", "stored code kept", int'(ddc1_active), 1);
    disable_tx();
  endtask

  task automatic t_disable_restart();
    int p0;
    write_mode(3'b000);
    enable_tx();
    send_byte(0, "R2");
    send_byte(1, "R2");
    // stop on a slot that drives low, if any
    p0 = 0;
    for (int p = 7; p >= 0; p--) if (!pat(2)[7-p]) p0 = p;
    for (int p = 0; p <= p0; p++) slot(pat(2), p, "R2");
    cfg_en = 1'b0; wait_cyc(4);
    check(sda_drive_low == 1'b0, "R7", "released when disabled",
          int'(sda_drive_low), 0);
    wait_cyc(4);
    enable_tx();
    check(rd_cnt == 1 && rd_log[0] == 7'd0, "R7", "restart address",
          int'(rd_log[0]), 0);
    send_byte(0, "R7");
    disable_tx();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_modes();
    t_stream();
    t_wrap();
    t_locked_mode();
    t_disable_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule